// File: doc/BRIEF.md
# Eight-bit ALU with flag register

This block computes the data path result of an accumulator-style processor in a single cycle. It also holds the processor's status flags: negative, overflow, zero, carry and decimal. Each cycle the decoder presents an operation code, a register operand and a memory operand. Within the same cycle the block returns:

- the 8-bit result and a flag saying whether the result is to be written back;
- the candidate new values for N, V, Z and C;
- one write enable for each of those four flags.

On the next rising clock edge the flag register takes the candidate value of every flag whose enable is high and keeps its old value for every other flag. The carry that arithmetic, rotates and subtraction consume is the stored carry flag. Decimal mode is kept only as a stored bit that software can set and clear; it never changes arithmetic. The decoder idles the block by presenting an unused operation code.

Top module: `alu8_flags`

## Requirements
- R1: After reset all five stored flags read 0.
- R2: Op code 0 (add) gives R = A + M + C modulo 256. The new C is 1 when the full sum exceeds 255. The new V is bit 7 of (R^A)&(R^M). N, V, Z and C are all written.
- R3: Op code 1 (subtract) gives R = A + ~M + C modulo 256. The new C is 1 exactly when no borrow occurred. V follows the R2 rule with ~M in place of M. All four flags are written.
- R4: Op code 6 (compare) writes no result (result 0, res_we 0). It sets C when A >= M unsigned, sets Z when A == M, and sets N from bit 7 of (A-M) mod 256. V is never written.
- R5: Op code 5 (bit test) writes no result. It sets Z when (A & M) == 0, takes N from M bit 7 and V from M bit 6, and leaves C alone.
- R6: Op codes 2, 3 and 4 (AND, OR, XOR of A and M) write only N and Z.
- R7: Op codes 7 and 8 (A+1 and A-1, modulo 256) write only N and Z. C and V keep their values.
- R8: Op code 9 shifts A left, moving bit 7 into C and 0 into bit 0. Op code 10 shifts A right, moving bit 0 into C and 0 into bit 7. Both write N, Z and C.
- R9: Op code 11 rotates A left, taking C into bit 0 and sending bit 7 to C. Op code 12 rotates A right, taking C into bit 7 and sending bit 0 to C. Nine chained rotates in one direction restore both the value and the carry.
- R10: Op code 13 (load) passes M to the result and writes N and Z from it. Op code 14 (move) passes M to the result and writes no flag.
- R11: Op code 15 sets and op code 16 clears the stored decimal flag. Neither writes a result or any of N, V, Z or C. The decimal flag never changes add or subtract.
- R12: Any op code from 17 to 31 gives result 0, res_we 0 and no flag write enable, so no flag changes.
- R13: On each clock edge a flag with its enable high takes its candidate value. A flag with its enable low holds. Every result-writing op except move sets Z when the result is 0 and copies result bit 7 into N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 5 | Operation code |
| a_in | input | 8 | Register operand |
| m_in | input | 8 | Memory operand |
| result | output | 8 | Combinational result |
| res_we | output | 1 | Result is to be written back |
| nxt_n | output | 1 | Candidate negative flag |
| nxt_v | output | 1 | Candidate overflow flag |
| nxt_z | output | 1 | Candidate zero flag |
| nxt_c | output | 1 | Candidate carry flag |
| we_n | output | 1 | Negative flag write enable |
| we_v | output | 1 | Overflow flag write enable |
| we_z | output | 1 | Zero flag write enable |
| we_c | output | 1 | Carry flag write enable |
| flag_n | output | 1 | Stored negative flag |
| flag_v | output | 1 | Stored overflow flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag |
| flag_d | output | 1 | Stored decimal flag |

## Verification
The hardest cases to reach are those that depend on the stored flags. The carry that add, subtract and the rotates consume, and the flags that a partial-update op must leave alone, can only be set by earlier operations. The stimulus therefore first prepares a known flag state and then runs the op under test:

- a subtract that underflows, or a compare, sets or clears the carry;
- a bit test with a chosen memory byte sets or clears the overflow.

The nine-rotate sequence feeds each result back as the next register operand, so the stored carry carries the state from one step to the next.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [4:0]   op,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] m_in,
  output logic [W-1:0] result,
  output logic         res_we,
  output logic         nxt_n,
  output logic         nxt_v,
  output logic         nxt_z,
  output logic         nxt_c,
  output logic         we_n,
  output logic         we_v,
  output logic         we_z,
  output logic         we_c,
  output logic         flag_n,
  output logic         flag_v,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_d
);
  localparam int MSB = W - 1;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0, OP_SUB = 5'd1, OP_AND = 5'd2, OP_OR  = 5'd3,
    OP_XOR = 5'd4, OP_BIT = 5'd5, OP_CMP = 5'd6, OP_INC = 5'd7,
    OP_DEC = 5'd8, OP_SHL = 5'd9, OP_SHR = 5'd10, OP_RTL = 5'd11,
    OP_RTR = 5'd12, OP_LD = 5'd13, OP_MOV = 5'd14, OP_SD = 5'd15,
    OP_CD  = 5'd16
  } alu_op_e;

  alu_op_e opc;
  assign opc = alu_op_e'(op);

  logic         sub_sel;
  logic [W-1:0] addend;
  logic [W:0]   sum;
  logic [W:0]   diff;
  logic         nz_from_res;

  assign sub_sel = (op == OP_SUB);
  assign addend  = sub_sel ? ~m_in : m_in;
  assign sum     = {1'b0, a_in} + {1'b0, addend} + {{W{1'b0}}, flag_c};
  assign diff    = {1'b0, a_in} + {1'b0, ~m_in} + {{W{1'b0}}, 1'b1};

  always_comb begin
    result      = '0;
    res_we      = 1'b0;
    nz_from_res = 1'b0;
    nxt_v       = 1'b0;
    nxt_c       = 1'b0;
    nxt_n       = 1'b0;
    nxt_z       = 1'b0;
    we_v        = 1'b0;
    we_c        = 1'b0;
    unique case (opc)
      OP_ADD, OP_SUB: begin
        result = sum[MSB:0];
        res_we = 1'b1;
        nz_from_res = 1'b1;
        nxt_c = sum[W];
        nxt_v = (sum[MSB] ^ a_in[MSB]) & (sum[MSB] ^ addend[MSB]);
        we_c = 1'b1;
        we_v = 1'b1;
      end
      OP_AND: begin result = a_in & m_in; res_we = 1'b1; nz_from_res = 1'b1; end
      OP_OR:  begin result = a_in | m_in; res_we = 1'b1; nz_from_res = 1'b1; end
      OP_XOR: begin result = a_in ^ m_in; res_we = 1'b1; nz_from_res = 1'b1; end
      OP_BIT: begin
        nxt_n = m_in[MSB];
        nxt_v = m_in[MSB-1];
        nxt_z = ~|(a_in & m_in);
        we_v  = 1'b1;
      end
      OP_CMP: begin
        nxt_n = diff[MSB];
        nxt_z = (a_in == m_in);
        nxt_c = diff[W];
        we_c  = 1'b1;
      end
      OP_INC: begin result = a_in + 1'b1; res_we = 1'b1; nz_from_res = 1'b1; end
      OP_DEC: begin result = a_in - 1'b1; res_we = 1'b1; nz_from_res = 1'b1; end
      OP_SHL: begin
        result = {a_in[MSB-1:0], 1'b0}; nxt_c = a_in[MSB];
        res_we = 1'b1; nz_from_res = 1'b1; we_c = 1'b1;
      end
      OP_SHR: begin
        result = {1'b0, a_in[MSB:1]}; nxt_c = a_in[0];
        res_we = 1'b1; nz_from_res = 1'b1; we_c = 1'b1;
      end
      OP_RTL: begin
        result = {a_in[MSB-1:0], flag_c}; nxt_c = a_in[MSB];
        res_we = 1'b1; nz_from_res = 1'b1; we_c = 1'b1;
      end
      OP_RTR: begin
        result = {flag_c, a_in[MSB:1]}; nxt_c = a_in[0];
        res_we = 1'b1; nz_from_res = 1'b1; we_c = 1'b1;
      end
      OP_LD:  begin result = m_in; res_we = 1'b1; nz_from_res = 1'b1; end
      OP_MOV: begin result = m_in; res_we = 1'b1; end
      default: ;
    endcase
    if (nz_from_res) begin
      nxt_n = result[MSB];
      nxt_z = (result == '0);
    end
  end

  assign we_n = nz_from_res | (op == OP_BIT) | (op == OP_CMP);
  assign we_z = we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_n <= 1'b0;
      flag_v <= 1'b0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
      flag_d <= 1'b0;
    end else begin
      if (we_n) flag_n <= nxt_n;
      if (we_v) flag_v <= nxt_v;
      if (we_z) flag_z <= nxt_z;
      if (we_c) flag_c <= nxt_c;
      if (op == OP_SD) flag_d <= 1'b1;
      else if (op == OP_CD) flag_d <= 1'b0;
    end
  end
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] op,
  input logic [7:0] a_in,
  input logic [7:0] m_in,
  input logic [7:0] result,
  input logic       res_we,
  input logic       nxt_c,
  input logic       we_n,
  input logic       we_v,
  input logic       we_z,
  input logic       we_c,
  input logic       flag_n,
  input logic       flag_v,
  input logic       flag_z,
  input logic       flag_c,
  input logic       flag_d
);
  assert_cmp_keeps_v_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 5'd6) |=> $stable(flag_v));

  assert_bit_copies_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 5'd5) |=> (flag_n == $past(m_in[7])) && (flag_v == $past(m_in[6])));

  assert_incdec_keep_cv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 5'd7 || op == 5'd8) |=> $stable(flag_c) && $stable(flag_v));

  assert_move_no_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 5'd14) |=> $stable(flag_n) && $stable(flag_v) && $stable(flag_z) && $stable(flag_c));

  assert_unknown_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op > 5'd16) |-> (result == 8'd0) && !res_we && !we_n && !we_v && !we_z && !we_c);

  assert_carry_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !we_c |=> $stable(flag_c));

  assert_carry_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
    we_c |=> (flag_c == $past(nxt_c)));

  assert_sd_sets_d_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 5'd15) |=> flag_d);
endmodule

bind alu8_flags alu8_flags_chk chk_i (.*);

// File: tb/alu8_flags_tb_top.sv
module alu8_flags_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] op = 5'd31;
  logic [7:0] a_in = '0, m_in = '0;
  logic [7:0] result;
  logic res_we, nxt_n, nxt_v, nxt_z, nxt_c, we_n, we_v, we_z, we_c;
  logic flag_n, flag_v, flag_z, flag_c, flag_d;

  int n_cmp = 0, n_bad = 0;
  int mn = 0, mv = 0, mz = 0, mc = 0, md = 0;

  always #5 clk = ~clk;

  alu8_flags dut_i (.*);

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input int o, input int a, input int m, input string tag);
    int r, rwe, wn, wv, wz, wc, en, ev, ez, ec, s, nz;
    @(negedge clk);
    op = o[4:0]; a_in = a[7:0]; m_in = m[7:0];
    #1;
    chk({flag_n, flag_v, flag_z, flag_c, flag_d} == {mn[0], mv[0], mz[0], mc[0], md[0]},
        tag, "flags", {flag_n, flag_v, flag_z, flag_c, flag_d}, {mn[0], mv[0], mz[0], mc[0], md[0]});
    r = 0; rwe = 0; wn = 0; wv = 0; wz = 0; wc = 0; en = 0; ev = 0; ez = 0; ec = 0; nz = 0;
    case (o)
      0:  begin s = a + m + mc; r = s % 256; ec = s > 255; ev = (((r ^ a) & (r ^ m)) >> 7) & 1; wv = 1; wc = 1; nz = 1; end
      1:  begin s = a + (255 - m) + mc; r = s % 256; ec = s > 255; ev = (((r ^ a) & (r ^ (255 - m))) >> 7) & 1; wv = 1; wc = 1; nz = 1; end
      2:  begin r = a & m; nz = 1; end
      3:  begin r = a | m; nz = 1; end
      4:  begin r = a ^ m; nz = 1; end
      5:  begin ez = (a & m) == 0; en = m >= 128; ev = (m / 64) % 2; wn = 1; wz = 1; wv = 1; end
      6:  begin ec = a >= m; ez = a == m; en = ((a - m + 256) % 256) >= 128; wn = 1; wz = 1; wc = 1; end
      7:  begin r = (a + 1) % 256; nz = 1; end
      8:  begin r = (a + 255) % 256; nz = 1; end
      9:  begin r = (a * 2) % 256; ec = a >= 128; wc = 1; nz = 1; end
      10: begin r = a / 2; ec = a % 2; wc = 1; nz = 1; end
      11: begin r = (a * 2 + mc) % 256; ec = a >= 128; wc = 1; nz = 1; end
      12: begin r = a / 2 + mc * 128; ec = a % 2; wc = 1; nz = 1; end
      13: begin r = m; nz = 1; end
      14: begin r = m; rwe = 1; end
      default: ;
    endcase
    if (nz) begin rwe = 1; wn = 1; wz = 1; en = r >= 128; ez = r == 0; end
    chk(result == r[7:0] && res_we == rwe[0], tag, "result", {res_we, result}, rwe * 256 + r);
    chk({we_n, we_v, we_z, we_c} == {wn[0], wv[0], wz[0], wc[0]}, tag, "enables",
        {we_n, we_v, we_z, we_c}, {wn[0], wv[0], wz[0], wc[0]});
    if (wn) chk(nxt_n == en[0], tag, "nxt_n", nxt_n, en);
    if (wv) chk(nxt_v == ev[0], tag, "nxt_v", nxt_v, ev);
    if (wz) chk(nxt_z == ez[0], tag, "nxt_z", nxt_z, ez);
    if (wc) chk(nxt_c == ec[0], tag, "nxt_c", nxt_c, ec);
    if (wn) mn = en;
    if (wv) mv = ev;
    if (wz) mz = ez;
    if (wc) mc = ec;
    if (o == 15) md = 1;
    if (o == 16) md = 0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int v0, c0;
    repeat (3) @(negedge clk);
    chk({flag_n, flag_v, flag_z, flag_c, flag_d} == 5'b0, "R1", "reset flags",
        {flag_n, flag_v, flag_z, flag_c, flag_d}, 0);
    rst_n = 1'b1;
    step(31, 0, 0, "R1");
    // add: plain, carry out, signed overflow
    step(0, 8'h10, 8'h22, "R2");
    step(0, 8'hF0, 8'h20, "R2");
    step(0, 8'h50, 8'h50, "R2");
    step(0, 8'h80, 8'h80, "R2");
    // subtract: no borrow, underflow, signed overflow
    step(1, 8'h50, 8'h10, "R3");
    step(1, 8'h10, 8'h20, "R3");
    step(1, 8'h80, 8'h01, "R3");
    // bit test sets V, then compare must keep it
    step(5, 8'h00, 8'hC0, "R5");
    step(6, 8'h40, 8'h40, "R4");
    step(6, 8'h10, 8'h40, "R4");
    step(6, 8'hFF, 8'h00, "R4");
    step(5, 8'h0F, 8'h3F, "R5");
    step(5, 8'h00, 8'h80, "R5");
    // logic ops keep C and V
    step(0, 8'h70, 8'h70, "R2");
    step(2, 8'hF0, 8'h0F, "R6");
    step(3, 8'h80, 8'h01, "R6");
    step(4, 8'hAA, 8'hAA, "R6");
    // inc/dec keep C and V
    step(7, 8'hFF, 0, "R7");
    step(8, 8'h00, 0, "R7");
    step(7, 8'h7F, 0, "R7");
    // shifts
    step(9, 8'h81, 0, "R8");
    step(10, 8'h01, 0, "R8");
    step(10, 8'hFE, 0, "R8");
    // rotates, nine in a row restore value and carry
    step(1, 8'h05, 8'h01, "R9");
    v0 = 8'hA5; c0 = mc;
    for (int i = 0; i < 9; i++) begin step(11, v0, 0, "R9"); v0 = result; end
    #5;
    chk(v0 == 8'hA5 && mc == c0, "R9", "rol x9", v0 * 2 + mc, 8'hA5 * 2 + c0);
    for (int i = 0; i < 9; i++) begin step(12, v0, 0, "R9"); v0 = result; end
    chk(v0 == 8'hA5 && mc == c0, "R9", "ror x9", v0 * 2 + mc, 8'hA5 * 2 + c0);
    // load and move
    step(13, 0, 8'h80, "R10");
    step(14, 0, 8'h00, "R10");
    step(13, 0, 8'h00, "R10");
    step(14, 0, 8'hFF, "R10");
    // decimal flag has no effect on add or subtract
    step(15, 0, 0, "R11");
    step(0, 8'h09, 8'h01, "R11");
    step(1, 8'h10, 8'h01, "R11");
    step(16, 0, 0, "R11");
    // unknown codes
    step(17, 8'hFF, 8'hFF, "R12");
    step(31, 8'h00, 8'h00, "R12");
    step(23, 8'h80, 8'h80, "R12");
    // hold and load of flags over consecutive edges
    step(0, 8'hFF, 8'h01, "R13");
    step(4, 8'h12, 8'h12, "R13");
    step(31, 0, 0, "R13");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule